// File: doc/BRIEF.md
# ADC Regular Sequence Controller

This block is the digital sequencing logic that sits in front of a multichannel successive-approximation converter. Software programs an ordered list of up to sixteen channel ranks, a 3-bit sample-time code for every input channel, and a set of mode bits. A scan starts on a software strobe or on a chosen edge of one of sixteen external trigger lines. The controller then walks the ranks. For each rank it opens a sample window of the programmed length, asks the converter for a result, and stores that result in a data register.

It reports progress through a start flag, an end-of-conversion flag with an interrupt, an overrun flag and a DMA request pulse. The converter itself is outside the block. The block puts out the channel number and a request, and the converter answers with a result and a valid strobe. Configuration arrives on a plain write port: a register select, a data word and a write strobe.

Register selects are 0 control, 1/2/3 rank groups, 4/5 sample-time groups. Control word bits:
- bit 0: enable
- bit 1: scan
- bit 2: continuous
- bit 3: flag after every conversion
- bit 4: interrupt enable
- bit 5: DMA enable
- bit 6: DMA keeps going
- bits 8:7: edge mode
- bits 12:9: trigger select

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the data register reads 0, all flags, `irq`, `dma_req`, `busy`, `smp_on` and `conv_req` are 0, and the programmed length is one conversion.
- R2: The sample window (`smp_on`) for a rank lasts exactly 3, 15, 28, 56, 84, 112, 144 or 480 clocks for codes 0 to 7 of that rank's channel. Channel c's code sits at bits [3c+2:3c] of select 4 for channels 0 to 9, and at bits [3(c-10)+2:3(c-10)] of select 5 for channels 10 to 18.
- R3: Rank placement:
  - Rank r (0-based) takes its channel from select 1+r/6, bits [5(r%6)+4:5(r%6)].
  - The length field (count minus one) is bits [27:24] of select 3.
  - With scan clear only rank 0 is converted.
  - With scan set, ranks 0 to length are converted in order.
- R4: Edge mode 0 ignores triggers, 1 starts on a rising edge, 2 on a falling edge and 3 on either edge. Only the line numbered by the trigger select counts.
- R5: In continuous mode the first start begins sequences that repeat back-to-back. Further starts or triggers do not disturb the rank order. Clearing enable stops conversion.
- R6: With control bit 3 set the end-of-conversion flag is raised after every conversion. With it clear the flag is raised only after the last rank. `irq` is the flag gated by control bit 4.
- R7: With DMA enabled and bit 6 clear, a `dma_req` pulse is issued per conversion for one sequence only, and the requests re-arm after DMA is disabled. With bit 6 set a pulse accompanies every conversion.
- R8: The start flag rises when a sequence begins and holds until `clr_strt`. The end-of-conversion flag holds until `clr_eoc`.
- R9: The overrun flag is set when a result overwrites an unread data register while DMA or per-conversion flags are enabled. It holds until `clr_ovr` and stays clear otherwise.
- R10: Start strobes and triggers are ignored while enable is clear.
- R11: Writes to selects 1 to 3 are ignored while a sequence is running.
- R12: The data register holds, right-aligned, the last result accepted from the converter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_data | input | 30 | Write data |
| sw_start | input | 1 | Software start strobe |
| clr_eoc | input | 1 | Clear end-of-conversion flag |
| clr_strt | input | 1 | Clear start flag |
| clr_ovr | input | 1 | Clear overrun flag |
| data_rd | input | 1 | Data register has been read |
| ext_trig | input | 16 | External trigger lines |
| res_valid | input | 1 | Converter result valid |
| res_data | input | 12 | Converter result |
| smp_on | output | 1 | Sample window open |
| conv_req | output | 1 | Conversion requested |
| conv_ch | output | 5 | Channel of current rank |
| busy | output | 1 | Sequence running |
| data_out | output | 12 | Data register |
| eoc_flag | output | 1 | End-of-conversion flag |
| strt_flag | output | 1 | Start flag |
| ovr_flag | output | 1 | Overrun flag |
| irq | output | 1 | Interrupt |
| dma_req | output | 1 | DMA request pulse |

## Verification
The bench builds the block with its default parameters: sixteen ranks, nineteen channels, 5-bit channel numbers, 12-bit results and sixteen trigger lines. These values put the full sixteen-rank list within reach, including the third rank group and the length field, as well as both sample-time groups. The bench sweeps all eight sample codes, every edge mode on a selected line and an unselected one, and both flag and DMA modes. Window lengths, rank order and result words are computed arithmetically in the bench and compared against what the converter model observes.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int CFG_W          = 30;
  localparam int SEL_W          = 3;
  localparam int REG_CTRL       = 0;
  localparam int REG_RANK0      = 1;
  localparam int REG_SMP0       = 4;
  localparam int RANKS_PER_REG  = 6;
  localparam int SMP_PER_REG    = 10;
  localparam int SMP_W          = 3;
  localparam int LEN_LSB        = 24;
  localparam int CNT_W          = 9;

  typedef struct packed {
    logic [3:0] trig_sel;
    logic [1:0] edge_mode;
    logic       dma_sticky;
    logic       dma_en;
    logic       irq_en;
    logic       eoc_each;
    logic       cont;
    logic       scan;
    logic       en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  typedef enum logic [1:0] {ST_IDLE, ST_SAMPLE, ST_CONV} seq_state_t;

  // sample window length in converter clocks for a 3-bit code
  function automatic logic [CNT_W-1:0] samp_cycles(input logic [SMP_W-1:0] code);
    case (code)
      3'd0:    samp_cycles = CNT_W'(3);
      3'd1:    samp_cycles = CNT_W'(15);
      3'd2:    samp_cycles = CNT_W'(28);
      3'd3:    samp_cycles = CNT_W'(56);
      3'd4:    samp_cycles = CNT_W'(84);
      3'd5:    samp_cycles = CNT_W'(112);
      3'd6:    samp_cycles = CNT_W'(144);
      default: samp_cycles = CNT_W'(480);
    endcase
  endfunction
endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
#(
  parameter int NUM_RANKS = 16,
  parameter int NUM_CH    = 19,
  parameter int CH_W      = 5,
  parameter int LEN_W     = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cfg_wr,
  input  logic [SEL_W-1:0]                  cfg_sel,
  input  logic [CFG_W-1:0]                  cfg_data,
  input  logic                              busy,
  output ctrl_t                             ctrl,
  output logic [NUM_RANKS-1:0][CH_W-1:0]    rank_ch,
  output logic [NUM_CH-1:0][SMP_W-1:0]      smp_code,
  output logic [LEN_W-1:0]                  seq_len
);
  localparam int LAST_RANK_REG = REG_RANK0 + (NUM_RANKS - 1) / RANKS_PER_REG;

  logic seq_wr_ok;
  logic seq_sel_hit;
  assign seq_wr_ok   = cfg_wr && !busy;
  assign seq_sel_hit = cfg_wr && (int'(cfg_sel) >= REG_RANK0) && (int'(cfg_sel) <= LAST_RANK_REG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl    <= '0;
      seq_len <= '0;
    end else begin
      if (cfg_wr && cfg_sel == SEL_W'(REG_CTRL))
        ctrl <= ctrl_t'(cfg_data[CTRL_W-1:0]);
      if (seq_wr_ok && cfg_sel == SEL_W'(LAST_RANK_REG))
        seq_len <= cfg_data[LEN_LSB +: LEN_W];
    end
  end

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
    localparam int RREG  = REG_RANK0 + r / RANKS_PER_REG;
    localparam int RSLOT = r % RANKS_PER_REG;
    logic [CH_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else if (seq_wr_ok && cfg_sel == SEL_W'(RREG)) q <= cfg_data[RSLOT*CH_W +: CH_W];
    end
    assign rank_ch[r] = q;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_smp
    localparam int SREG  = REG_SMP0 + c / SMP_PER_REG;
    localparam int SSLOT = c % SMP_PER_REG;
    logic [SMP_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else if (cfg_wr && cfg_sel == SEL_W'(SREG)) q <= cfg_data[SSLOT*SMP_W +: SMP_W];
    end
    assign smp_code[c] = q;
  end

  // R11: rank list and length frozen while a sequence runs
  a_r11_seq_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && seq_sel_hit) |=> ($stable(rank_ch) && $stable(seq_len)));
endmodule

// File: rtl/adc_seq_trig.sv
module adc_seq_trig #(
  parameter int NUM_TRIG = 16,
  parameter int TSEL_W   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_TRIG-1:0] ext_trig,
  input  logic [TSEL_W-1:0]   trig_sel,
  input  logic [1:0]          edge_mode,
  output logic                trig_hit
);
  logic [NUM_TRIG-1:0] prev;
  logic cur, old, rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= ext_trig;
  end

  assign cur  = ext_trig[trig_sel];
  assign old  = prev[trig_sel];
  assign rise = cur && !old;
  assign fall = !cur && old;

  always_comb begin
    case (edge_mode)
      2'd1:    trig_hit = rise;
      2'd2:    trig_hit = fall;
      2'd3:    trig_hit = rise || fall;
      default: trig_hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int NUM_RANKS = 16,
  parameter int NUM_CH    = 19,
  parameter int CH_W      = 5,
  parameter int LEN_W     = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           en,
  input  logic                           scan,
  input  logic                           cont,
  input  logic [NUM_RANKS-1:0][CH_W-1:0] rank_ch,
  input  logic [NUM_CH-1:0][SMP_W-1:0]   smp_code,
  input  logic [LEN_W-1:0]               seq_len,
  input  logic                           start_req,
  input  logic                           res_valid,
  output logic                           busy,
  output logic                           smp_on,
  output logic                           conv_req,
  output logic [CH_W-1:0]                conv_ch,
  output logic                           conv_done,
  output logic                           seq_start,
  output logic                           seq_end
);
  localparam int PAD_CH = 2**CH_W;

  seq_state_t state;
  logic [LEN_W-1:0] rank, last_rank, load_rank;
  logic [CNT_W-1:0] cnt;
  logic [PAD_CH-1:0][SMP_W-1:0] code_pad;
  logic [CH_W-1:0]  load_ch;
  logic [SMP_W-1:0] load_code;
  logic start_go, is_last, restart, advance, load;

  assign code_pad  = {{((PAD_CH - NUM_CH) * SMP_W){1'b0}}, smp_code};
  assign last_rank = scan ? seq_len : '0;
  assign is_last   = (rank == last_rank);
  assign start_go  = (state == ST_IDLE) && en && start_req;
  assign conv_done = (state == ST_CONV) && res_valid && en;
  assign seq_end   = conv_done && is_last;
  assign restart   = seq_end && cont;
  assign advance   = conv_done && !is_last;
  assign load      = start_go || restart || advance;
  assign seq_start = start_go || restart;
  assign load_rank = advance ? LEN_W'(rank + 1'b1) : '0;
  assign load_ch   = rank_ch[load_rank];
  assign load_code = code_pad[load_ch];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      rank  <= '0;
      cnt   <= '0;
    end else if (!en) begin
      state <= ST_IDLE;
    end else if (load) begin
      state <= ST_SAMPLE;
      rank  <= load_rank;
      cnt   <= samp_cycles(load_code) - 1'b1;
    end else if (state == ST_SAMPLE) begin
      if (cnt == '0) state <= ST_CONV;
      else           cnt   <= cnt - 1'b1;
    end else if (conv_done) begin
      state <= ST_IDLE;
    end
  end

  assign busy     = (state != ST_IDLE);
  assign smp_on   = (state == ST_SAMPLE);
  assign conv_req = (state == ST_CONV);
  assign conv_ch  = rank_ch[rank];

  // R10: a disabled controller stays idle
  a_r10_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !en) |=> (state == ST_IDLE));
  // R3: the walker never passes the programmed length
  a_r3_rank_bound: assert property (@(posedge clk) disable iff (!rst_n)
    smp_on |-> (rank <= seq_len));
  // R5: continuous mode restarts at the first rank
  a_r5_cont_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_end && cont) |=> (smp_on && rank == '0));
endmodule

// File: rtl/adc_seq_flags.sv
module adc_seq_flags #(
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eoc_each,
  input  logic             irq_en,
  input  logic             dma_en,
  input  logic             dma_sticky,
  input  logic             conv_done,
  input  logic             seq_start,
  input  logic             seq_end,
  input  logic [RES_W-1:0] res_data,
  input  logic             clr_eoc,
  input  logic             clr_strt,
  input  logic             clr_ovr,
  input  logic             data_rd,
  output logic [RES_W-1:0] data_out,
  output logic             eoc_flag,
  output logic             strt_flag,
  output logic             ovr_flag,
  output logic             irq,
  output logic             dma_req
);
  logic unread, dma_spent;
  logic eoc_set, ovr_hit, dma_live;

  assign eoc_set  = conv_done && (eoc_each || seq_end);
  assign ovr_hit  = conv_done && unread && (dma_en || eoc_each);
  assign dma_live = dma_en && (dma_sticky || !dma_spent);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_out  <= '0;
      eoc_flag  <= 1'b0;
      strt_flag <= 1'b0;
      ovr_flag  <= 1'b0;
      unread    <= 1'b0;
      dma_spent <= 1'b0;
      dma_req   <= 1'b0;
    end else begin
      if (conv_done) data_out <= res_data;
      if (eoc_set)        eoc_flag <= 1'b1;
      else if (clr_eoc)   eoc_flag <= 1'b0;
      if (seq_start)      strt_flag <= 1'b1;
      else if (clr_strt)  strt_flag <= 1'b0;
      if (ovr_hit)        ovr_flag <= 1'b1;
      else if (clr_ovr)   ovr_flag <= 1'b0;
      if (conv_done)      unread <= 1'b1;
      else if (data_rd)   unread <= 1'b0;
      if (!dma_en)                 dma_spent <= 1'b0;
      else if (seq_end && !dma_sticky) dma_spent <= 1'b1;
      dma_req <= conv_done && dma_live;
    end
  end

  assign irq = eoc_flag && irq_en;

  // R12: accepted result lands in the data register
  a_r12_data_capture: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> (data_out == $past(res_data)));
  // R6: sequence end always raises the flag
  a_r6_seq_end_eoc: assert property (@(posedge clk) disable iff (!rst_n)
    seq_end |=> eoc_flag);
  // R8: start flag holds until cleared
  a_r8_strt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (strt_flag && !clr_strt) |=> strt_flag);
  // R7: no request without DMA enabled
  a_r7_dma_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> $past(dma_en));
  // R9: overrun holds until cleared
  a_r9_ovr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_flag && !clr_ovr) |=> ovr_flag);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NUM_RANKS = 16,
  parameter int NUM_CH    = 19,
  parameter int CH_W      = 5,
  parameter int RES_W     = 12,
  parameter int NUM_TRIG  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_wr,
  input  logic [SEL_W-1:0]    cfg_sel,
  input  logic [CFG_W-1:0]    cfg_data,
  input  logic                sw_start,
  input  logic                clr_eoc,
  input  logic                clr_strt,
  input  logic                clr_ovr,
  input  logic                data_rd,
  input  logic [NUM_TRIG-1:0] ext_trig,
  input  logic                res_valid,
  input  logic [RES_W-1:0]    res_data,
  output logic                smp_on,
  output logic                conv_req,
  output logic [CH_W-1:0]     conv_ch,
  output logic                busy,
  output logic [RES_W-1:0]    data_out,
  output logic                eoc_flag,
  output logic                strt_flag,
  output logic                ovr_flag,
  output logic                irq,
  output logic                dma_req
);
  localparam int LEN_W = $clog2(NUM_RANKS);

  ctrl_t ctrl;
  logic [NUM_RANKS-1:0][CH_W-1:0] rank_ch;
  logic [NUM_CH-1:0][SMP_W-1:0]   smp_code;
  logic [LEN_W-1:0] seq_len;
  logic trig_hit, start_req, conv_done, seq_start, seq_end;

  assign start_req = sw_start || trig_hit;

  adc_seq_regs #(.NUM_RANKS(NUM_RANKS), .NUM_CH(NUM_CH), .CH_W(CH_W), .LEN_W(LEN_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .busy(busy), .ctrl(ctrl), .rank_ch(rank_ch), .smp_code(smp_code), .seq_len(seq_len));

  adc_seq_trig #(.NUM_TRIG(NUM_TRIG), .TSEL_W(4)) u_trig (
    .clk(clk), .rst_n(rst_n), .ext_trig(ext_trig), .trig_sel(ctrl.trig_sel),
    .edge_mode(ctrl.edge_mode), .trig_hit(trig_hit));

  adc_seq_fsm #(.NUM_RANKS(NUM_RANKS), .NUM_CH(NUM_CH), .CH_W(CH_W), .LEN_W(LEN_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .en(ctrl.en), .scan(ctrl.scan), .cont(ctrl.cont),
    .rank_ch(rank_ch), .smp_code(smp_code), .seq_len(seq_len), .start_req(start_req),
    .res_valid(res_valid), .busy(busy), .smp_on(smp_on), .conv_req(conv_req),
    .conv_ch(conv_ch), .conv_done(conv_done), .seq_start(seq_start), .seq_end(seq_end));

  adc_seq_flags #(.RES_W(RES_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .eoc_each(ctrl.eoc_each), .irq_en(ctrl.irq_en),
    .dma_en(ctrl.dma_en), .dma_sticky(ctrl.dma_sticky), .conv_done(conv_done),
    .seq_start(seq_start), .seq_end(seq_end), .res_data(res_data), .clr_eoc(clr_eoc),
    .clr_strt(clr_strt), .clr_ovr(clr_ovr), .data_rd(data_rd), .data_out(data_out),
    .eoc_flag(eoc_flag), .strt_flag(strt_flag), .ovr_flag(ovr_flag), .irq(irq),
    .dma_req(dma_req));
endmodule

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;
  localparam int C_EN = 1, C_SCAN = 2, C_CONT = 4, C_EACH = 8, C_IE = 16, C_DMA = 32, C_STICKY = 64;
  localparam int ST_TAB [8] = '{3, 15, 28, 56, 84, 112, 144, 480};

  logic clk = 0, rst_n = 0;
  logic cfg_wr = 0; logic [2:0] cfg_sel = 0; logic [29:0] cfg_data = 0;
  logic sw_start = 0, clr_eoc = 0, clr_strt = 0, clr_ovr = 0, data_rd = 0;
  logic [15:0] ext_trig = 0;
  logic res_valid = 0; logic [11:0] res_data = 0;
  logic smp_on, conv_req, busy, eoc_flag, strt_flag, ovr_flag, irq, dma_req;
  logic [4:0] conv_ch; logic [11:0] data_out;

  int n_chk = 0, n_err = 0, cyc = 0, log_n = 0, cur_smp = 0, dma_cnt = 0;
  int log_ch [512]; int log_smp [512]; int log_eoc [512];

  adc_seq_ctrl u_dut (.clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .sw_start(sw_start), .clr_eoc(clr_eoc), .clr_strt(clr_strt), .clr_ovr(clr_ovr), .data_rd(data_rd),
    .ext_trig(ext_trig), .res_valid(res_valid), .res_data(res_data), .smp_on(smp_on), .conv_req(conv_req),
    .conv_ch(conv_ch), .busy(busy), .data_out(data_out), .eoc_flag(eoc_flag), .strt_flag(strt_flag),
    .ovr_flag(ovr_flag), .irq(irq), .dma_req(dma_req));

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%0d expected=finish", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  // converter model: answers each request on the next edge
  always @(negedge clk) begin
    if (smp_on) cur_smp++;
    if (dma_req) dma_cnt++;
    if (conv_req && !res_valid) begin
      log_ch[log_n & 511] = int'(conv_ch);
      log_smp[log_n & 511] = cur_smp;
      log_eoc[log_n & 511] = int'(eoc_flag);
      res_data = {conv_ch, 7'(log_n)};
      res_valid = 1'b1;
      log_n++;
      cur_smp = 0;
    end else res_valid = 1'b0;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int s, input int d);
    @(negedge clk); cfg_wr = 1; cfg_sel = 3'(s); cfg_data = 30'(d);
    @(negedge clk); cfg_wr = 0;
  endtask

  task automatic pulse(input int w);
    @(negedge clk);
    case (w) 0: sw_start = 1; 1: clr_eoc = 1; 2: clr_strt = 1; default: clr_ovr = 1; endcase
    @(negedge clk); sw_start = 0; clr_eoc = 0; clr_strt = 0; clr_ovr = 0;
  endtask

  task automatic run_seq();
    pulse(0);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  function automatic int expect_res(input int idx);
    return ((log_ch[idx & 511] & 31) << 7) | (idx & 127);
  endfunction

  function automatic int rk(input int r); return (r * 5 + 1) % 19; endfunction

  task automatic load_ranks(input int len_field);
    int a = 0, b = 0, c = 0;
    for (int r = 0; r < 6; r++) a |= rk(r) << (5 * r);
    for (int r = 6; r < 12; r++) b |= rk(r) << (5 * (r - 6));
    for (int r = 12; r < 16; r++) c |= rk(r) << (5 * (r - 12));
    wr(1, a); wr(2, b); wr(3, c | (len_field << 24));
  endtask

  initial begin
    int base, smp_rep, mism, cnt0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 data", int'(data_out), 0);
    chk("R1 flags", int'({eoc_flag, strt_flag, ovr_flag, irq, dma_req}), 0);
    chk("R1 idle", int'({busy, smp_on, conv_req}), 0);
    wr(1, 4);
    wr(0, C_EN); run_seq();
    chk("R1 length one", log_n, 1);
    // R10 disabled ignores start and trigger
    wr(0, 1 << 7); base = log_n;
    pulse(0); ext_trig[0] = 1; repeat (30) @(negedge clk); ext_trig[0] = 0; repeat (5) @(negedge clk);
    chk("R10 busy", int'(busy), 0);
    chk("R10 no conversion", log_n - base, 0);
    // R2 / R12 sweep of all codes on channels 0..9 group
    for (int k = 0; k < 8; k++) begin
      smp_rep = 0;
      for (int s = 0; s < 10; s++) smp_rep |= k << (3 * s);
      wr(4, smp_rep); wr(1, k + 1); wr(0, C_EN);
      cur_smp = 0; base = log_n; run_seq();
      chk("R2 window", log_smp[base & 511], ST_TAB[k]);
      chk("R3 channel", log_ch[base & 511], k + 1);
      chk("R12 data", int'(data_out), expect_res(base));
    end
    // R2 high group: channel 17 code 6
    wr(4, 0); wr(5, 6 << 21); wr(1, 17); cur_smp = 0; base = log_n; run_seq();
    chk("R2 high group window", log_smp[base & 511], 144);
    chk("R12 data high", int'(data_out), expect_res(base));
    wr(5, 0);
    // R3 full sixteen-rank scan
    load_ranks(15); wr(0, C_EN | C_SCAN); base = log_n; run_seq();
    chk("R3 scan count", log_n - base, 16);
    mism = 0;
    for (int r = 0; r < 16; r++) if (log_ch[(base + r) & 511] != rk(r)) mism++;
    chk("R3 scan order", mism, 0);
    wr(0, C_EN); base = log_n; run_seq();
    chk("R3 no scan count", log_n - base, 1);
    chk("R3 no scan channel", log_ch[base & 511], rk(0));
    // R6 per-sequence versus per-conversion flag
    load_ranks(3); pulse(1); wr(0, C_EN | C_SCAN); base = log_n; run_seq();
    chk("R6 seq mode mid flag", log_eoc[(base + 1) & 511], 0);
    chk("R6 seq mode end flag", int'(eoc_flag), 1);
    chk("R6 irq masked", int'(irq), 0);
    pulse(1); wr(0, C_EN | C_SCAN | C_EACH | C_IE); base = log_n; run_seq();
    chk("R6 each mode mid flag", log_eoc[(base + 1) & 511], 1);
    chk("R6 irq", int'(irq), 1);
    // R8 start and eoc flags
    pulse(2); chk("R8 strt cleared", int'(strt_flag), 0);
    run_seq(); chk("R8 strt held", int'(strt_flag), 1);
    pulse(2); chk("R8 strt clear again", int'(strt_flag), 0);
    pulse(1); chk("R8 eoc cleared", int'(eoc_flag), 0);
    // R9 overrun
    pulse(3); wr(0, C_EN | C_SCAN); run_seq();
    chk("R9 no overrun", int'(ovr_flag), 0);
    wr(0, C_EN | C_SCAN | C_EACH); run_seq();
    chk("R9 overrun", int'(ovr_flag), 1);
    pulse(3); chk("R9 cleared", int'(ovr_flag), 0);
    // R7 DMA one-shot then sticky
    wr(0, C_EN | C_SCAN | C_DMA); dma_cnt = 0; run_seq();
    chk("R7 one-shot first", dma_cnt, 4);
    run_seq(); chk("R7 one-shot stopped", dma_cnt, 4);
    wr(0, C_EN | C_SCAN); wr(0, C_EN | C_SCAN | C_DMA); run_seq();
    chk("R7 rearm", dma_cnt, 8);
    wr(0, C_EN | C_SCAN | C_DMA | C_STICKY); run_seq(); run_seq();
    chk("R7 sticky", dma_cnt, 16);
    // R4 edge modes on line 5
    for (int e = 0; e < 4; e++) begin
      wr(0, C_EN | (e << 7) | (5 << 9)); base = log_n;
      ext_trig[5] = 1; repeat (20) @(negedge clk);
      ext_trig[5] = 0; repeat (20) @(negedge clk);
      chk("R4 edge mode", log_n - base, (e == 0) ? 0 : (e == 3) ? 2 : 1);
    end
    base = log_n;
    ext_trig[4] = 1; repeat (20) @(negedge clk); ext_trig[4] = 0; repeat (20) @(negedge clk);
    chk("R4 unselected line", log_n - base, 0);
    // R5 continuous, ranks 2 then 9
    wr(1, 2 | (9 << 5)); wr(3, 1 << 24);
    wr(0, C_EN | C_SCAN | C_CONT | (1 << 7) | (5 << 9)); base = log_n;
    pulse(0);
    for (int i = 0; i < 4; i++) begin
      repeat (25) @(negedge clk); pulse(0);
      ext_trig[5] = 1; repeat (3) @(negedge clk); ext_trig[5] = 0;
    end
    chk("R5 still running", int'(busy), 1);
    wr(0, C_SCAN | C_CONT); repeat (5) @(negedge clk);
    chk("R5 stopped", int'(busy), 0);
    cnt0 = log_n - base;
    chk("R5 repeats", int'(cnt0 >= 10), 1);
    mism = 0;
    for (int i = 0; i < cnt0; i++) if (log_ch[(base + i) & 511] != ((i % 2) ? 9 : 2)) mism++;
    chk("R5 order kept", mism, 0);
    repeat (30) @(negedge clk);
    chk("R5 no more", log_n - base, cnt0);
    // R11 rank list locked while busy
    wr(4, 7 << 18); wr(1, 6); wr(0, C_EN);
    pulse(0); repeat (20) @(negedge clk); wr(1, 11);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    base = log_n; run_seq();
    chk("R11 locked", log_ch[base & 511], 6);
    wr(1, 11); base = log_n; run_seq();
    chk("R11 idle write", log_ch[base & 511], 11);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule